// File: doc/BRIEF.md
# Opcode-Dispatch Microsequencer

This block sequences a small four-instruction processor by reading control words from a fixed micro-program. It holds an eleven-word store, 17 bits per word. Sixteen bits of each word drive the datapath strobes. The seventeenth bit chooses where the next word comes from. The word being executed sits in a micro-instruction register, so all sixteen strobes leave the block straight from flip-flops. A 4-bit micro-address register points at that word.

Sequencing has only two moves. Normally the next address is the current one plus one. When the executing word carries the dispatch bit, a small opcode-mapping table supplies the next address instead. A word carrying the finish strobe returns the sequencer to the start of the fetch routine. A word carrying the memory-wait strobe freezes the sequencer until memory reports completion.

The fetch routine sits at words 0 to 2. The routines for the four opcodes start at words 3 (no-op), 4 (load), 5 (add) and 8 (subtract).

Top module: `useq_ctrl`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) clears the micro-address to 0. During the cycle right after reset is released, `ctrl_o` equals 16'h3087, the first fetch word.
- R2: Without stalls, the fetch routine presents `ctrl_o` = 16'h3087, 16'h0308, 16'h0030 on three consecutive cycles. Within a routine, words follow in ascending address order.
- R3: `opcode_i` is sampled at the rising edge that ends the cycle showing 16'h0030, the dispatch word. The routine that follows is 00 → 16'h8000; 01 → 16'h8810; 10 → 16'h0046, 16'h0098, 16'h8900; 11 → 16'h0046, 16'h6098, 16'h8900.
- R4: In the cycle after a word with `ctrl_o[15]` (finish) set has executed, `ctrl_o` shows 16'h3087 again.
- R5: While `ctrl_o[3]` (memory wait) is 1 and `mem_done_i` is 0, `ctrl_o` and the micro-address hold. The cycle after `mem_done_i` is seen high, the sequence moves on.
- R6: `mem_done_i` has no effect while `ctrl_o[3]` is 0. The sequence advances every cycle whatever its value.
- R7: `opcode_i` has no effect at any edge other than the one ending the dispatch word.
- R8: At most one of the bus-driving strobes is 1 in any cycle. These are `ctrl_o` bits 0 (PC drive), 4 (memory-data drive), 6 (instruction-register drive), 8 (Z drive) and 10 (accumulator drive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 2 | Opcode presented to the mapping table during the dispatch word |
| mem_done_i | input | 1 | Memory transfer complete |
| ctrl_o | output | 16 | Registered control strobes: 0 PC drive, 1 MAR load, 2 memory read, 3 memory wait, 4 MDR drive, 5 IR load, 6 IR drive, 7 Z load, 8 Z drive, 9 PC load, 10 AX drive, 11 AX load, 12 pass B, 13 carry in, 14 subtract, 15 finish |

## Verification
The bench runs all four opcodes. It crosses each with zero, one and three stall cycles on every memory-wait word, so routine length, dispatch target and stall hold are all told apart. On every word other than the dispatch word it drives the inverted opcode, which shows whether the mapping table samples only at the dispatch edge. On every non-wait word it holds memory-complete low, which shows that this input is ignored there. A reset asserted in the middle of a stalled add checks that the sequencer returns to the first fetch word from any state.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int AW    = 4;
  localparam int OPW   = 2;
  localparam int NSIG  = 16;
  localparam int CW    = NSIG + 1;
  localparam int DEPTH = 11;

  // strobe bit positions inside a control word
  localparam int B_PC_OE   = 0;
  localparam int B_MAR_LD  = 1;
  localparam int B_MEM_RD  = 2;
  localparam int B_WAIT    = 3;
  localparam int B_MDR_OE  = 4;
  localparam int B_IR_LD   = 5;
  localparam int B_IR_OE   = 6;
  localparam int B_Z_LD    = 7;
  localparam int B_Z_OE    = 8;
  localparam int B_PC_LD   = 9;
  localparam int B_AX_OE   = 10;
  localparam int B_AX_LD   = 11;
  localparam int B_PASS_B  = 12;
  localparam int B_CIN     = 13;
  localparam int B_SUB     = 14;
  localparam int B_FIN     = 15;
  localparam int B_DISP    = 16;

  // routine entry points
  localparam logic [AW-1:0] A_FETCH = 4'd0;
  localparam logic [AW-1:0] A_NOP   = 4'd3;
  localparam logic [AW-1:0] A_LOAD  = 4'd4;
  localparam logic [AW-1:0] A_ADD   = 4'd5;
  localparam logic [AW-1:0] A_SUB   = 4'd8;

  typedef logic [CW-1:0] cword_t;

  function automatic cword_t bit_of(input int b);
    cword_t w;
    w = '0;
    w[b] = 1'b1;
    return w;
  endfunction

  // micro-program contents, computed from strobe names
  function automatic cword_t cs_word(input int a);
    cword_t w;
    case (a)
      0: w = bit_of(B_PC_OE) | bit_of(B_MAR_LD) | bit_of(B_MEM_RD) |
             bit_of(B_PASS_B) | bit_of(B_CIN) | bit_of(B_Z_LD);
      1: w = bit_of(B_Z_OE) | bit_of(B_PC_LD) | bit_of(B_WAIT);
      2: w = bit_of(B_MDR_OE) | bit_of(B_IR_LD) | bit_of(B_DISP);
      3: w = bit_of(B_FIN);
      4: w = bit_of(B_MDR_OE) | bit_of(B_AX_LD) | bit_of(B_FIN);
      5, 8: w = bit_of(B_IR_OE) | bit_of(B_MAR_LD) | bit_of(B_MEM_RD);
      6: w = bit_of(B_WAIT) | bit_of(B_MDR_OE) | bit_of(B_Z_LD);
      9: w = bit_of(B_WAIT) | bit_of(B_MDR_OE) | bit_of(B_Z_LD) |
             bit_of(B_SUB) | bit_of(B_CIN);
      7, 10: w = bit_of(B_Z_OE) | bit_of(B_AX_LD) | bit_of(B_FIN);
      default: w = bit_of(B_FIN);
    endcase
    return w;
  endfunction
endpackage

// File: rtl/useq_map.sv
module useq_map
  import useq_pkg::*;
(
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  start
);
  always_comb begin
    case (opcode)
      2'b00:   start = A_NOP;
      2'b01:   start = A_LOAD;
      2'b10:   start = A_ADD;
      default: start = A_SUB;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           mem_done,
  input  logic           w_wait,
  input  logic           w_fin,
  input  logic           w_disp,
  output logic [AW-1:0]  upc,
  output logic [AW-1:0]  nxt,
  output logic           adv
);
  logic [AW-1:0] map_addr;
  logic [AW-1:0] inc_addr;
  logic          stall;

  useq_map u_map (.opcode(opcode), .start(map_addr));

  assign inc_addr = upc + AW'(1);
  assign stall    = w_wait & ~mem_done;
  assign adv      = ~stall;

  always_comb begin
    if (w_fin)       nxt = A_FETCH;
    else if (w_disp) nxt = map_addr;
    else             nxt = inc_addr;
  end

  always_ff @(posedge clk) begin
    if (rst)      upc <= A_FETCH;
    else if (adv) upc <= nxt;
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(upc));
  // R4
  fin_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (w_fin && adv) |=> (upc == A_FETCH));
  // R3
  disp_target_chk: assert property (@(posedge clk) disable iff (rst)
    (w_disp && adv) |=> (upc == A_NOP || upc == A_LOAD || upc == A_ADD || upc == A_SUB));
  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !w_fin && !w_disp) |=> (upc == $past(upc) + AW'(1)));
endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] nxt,
  output cword_t        uir
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = cs_word(i);
  end

  always_ff @(posedge clk) begin
    if (rst)
      uir <= cs_word(0);
    else if (adv)
      uir <= (nxt <= LAST) ? rom[nxt] : cs_word(DEPTH);
  end

  // R5
  uir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(uir));
  // R8
  one_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({uir[B_PC_OE], uir[B_MDR_OE], uir[B_IR_OE], uir[B_Z_OE], uir[B_AX_OE]}));
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  opcode_i,
  input  logic            mem_done_i,
  output logic [NSIG-1:0] ctrl_o
);
  cword_t        uir;
  logic [AW-1:0] upc;
  logic [AW-1:0] nxt;
  logic          adv;

  useq_next u_next (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode_i),
    .mem_done (mem_done_i),
    .w_wait   (uir[B_WAIT]),
    .w_fin    (uir[B_FIN]),
    .w_disp   (uir[B_DISP]),
    .upc      (upc),
    .nxt      (nxt),
    .adv      (adv)
  );

  useq_store u_store (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .nxt (nxt),
    .uir (uir)
  );

  assign ctrl_o = uir[NSIG-1:0];

  // R1
  reset_entry_chk: assert property (@(posedge clk)
    $fell(rst) |-> (upc == A_FETCH && ctrl_o == 16'h3087));
endmodule

// File: tb/useq_ctrl_tb.sv
`timescale 1ns/1ps
module useq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  opcode_i = 2'b00;
  logic        mem_done_i = 1'b0;
  logic [15:0] ctrl_o;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  useq_ctrl u_dut (.clk(clk), .rst(rst), .opcode_i(opcode_i),
                   .mem_done_i(mem_done_i), .ctrl_o(ctrl_o));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: cycles=%0d expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic [15:0] exp, input string tag);
    checks++;
    if (ctrl_o !== exp) begin
      fails++;
      $display("FAIL %s: ctrl_o=%h expected %h", tag, ctrl_o, exp);
    end
  endtask

  // check the word shown this cycle, then drive inputs for the edge that ends it
  task automatic step(input logic [15:0] exp, input logic done,
                      input logic [1:0] op, input string tag);
    @(negedge clk);
    chk(exp, tag);
    mem_done_i = done;
    opcode_i   = op;
    @(posedge clk);
  endtask

  // routine words per opcode (R3)
  function automatic logic [15:0] rtn_word(input int op, input int idx);
    case (op)
      0: return 16'h8000;
      1: return 16'h8810;
      2: return (idx == 0) ? 16'h0046 : (idx == 1) ? 16'h0098 : 16'h8900;
      default: return (idx == 0) ? 16'h0046 : (idx == 1) ? 16'h6098 : 16'h8900;
    endcase
  endfunction

  function automatic int rtn_len(input int op);
    return (op < 2) ? 1 : 3;
  endfunction

  // a word with bit 3 set: hold for nst cycles (R5), then complete
  task automatic wait_word(input logic [15:0] w, input int nst, input logic [1:0] op,
                           input string tag);
    for (int k = 0; k < nst; k++) step(w, 1'b0, op, "R5 stall hold");
    step(w, 1'b1, op, tag);
  endtask

  task automatic run_instr(input int op, input int nst, input bit first);
    logic [1:0] bad;
    bad = ~op[1:0];
    // R6: mem_done low on non-wait words; R7: wrong opcode off the dispatch edge
    step(16'h3087, 1'b0, bad, first ? "R2 fetch word 0" : "R4 restart after finish");
    wait_word(16'h0308, nst, bad, "R2 fetch word 1");
    step(16'h0030, 1'b0, op[1:0], "R2 dispatch word");
    for (int i = 0; i < rtn_len(op); i++) begin
      if (rtn_word(op, i) == 16'h0098 || rtn_word(op, i) == 16'h6098)
        wait_word(rtn_word(op, i), nst, bad, "R3 routine wait word");
      else
        step(rtn_word(op, i), 1'b0, bad, "R3 R6 R7 routine word");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(16'h3087, "R1 reset state");
    @(posedge clk);
    @(negedge clk);
    chk(16'h0308, "R2 second fetch word");
    // re-enter a clean reset before the sweep
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;

    for (int n = 0; n < 3; n++) begin
      for (int op = 0; op < 4; op++) begin
        run_instr(op, (n == 2) ? 3 : n, (n == 0 && op == 0));
      end
    end

    // R1: reset during a stalled add
    run_instr(0, 0, 1'b0);
    step(16'h3087, 1'b1, 2'b11, "R4 restart before mid reset");
    step(16'h0308, 1'b1, 2'b11, "R2 fetch word 1");
    step(16'h0030, 1'b0, 2'b10, "R2 dispatch word");
    step(16'h0046, 1'b0, 2'b00, "R3 add word 0");
    @(negedge clk);
    chk(16'h0098, "R5 stall before reset");
    mem_done_i = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1 rst = 1'b0;
    step(16'h3087, 1'b0, 2'b01, "R1 reset mid routine");
    step(16'h0308, 1'b1, 2'b01, "R1 fetch after reset");
    step(16'h0030, 1'b0, 2'b01, "R2 dispatch word");
    step(16'h8810, 1'b0, 2'b00, "R3 load word");
    @(negedge clk);
    chk(16'h3087, "R4 restart after load");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule